// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

A first-in first-out buffer of 512 words by 18 bits that joins two free-running clock domains. The producer writes on its own clock through a pair of write enables of opposite polarity and is paced by an input-ready flag. The consumer reads on its own clock through a read enable and two further active-low qualifiers, and is paced by an output-ready flag. The two clocks may be unrelated or the same.

The output is a registered buffer that fills by itself. When the memory holds data and the output buffer is empty, the oldest word moves into the buffer with no read request. Output-ready then reports that the data on the output is valid. A read accepts the buffered word and refills the buffer from memory in the same cycle. The word in the output buffer counts toward the 512-word capacity. A half-full flag and a combined near-empty/near-full flag are generated in the write domain. The near-empty/near-full threshold is captured while reset is held.

Reset is asynchronous and active low. It must be held across at least four edges of each clock. Input-ready rises a few write clocks after release.

Top module: `dcfifo_ft`

## Requirements
- R1: Words leave the FIFO in the order they were accepted, with their 18-bit values unchanged.
- R2: A word is accepted on a rising write-clock edge only when `wen_i` is 1, `wen_ni` is 0 and `ir_o` is 1. With either enable inactive, nothing is stored.
- R3: `ir_o` is 0 once 512 words are held, counting the word in the output buffer. Writes attempted while `ir_o` is 0 are dropped, so no more than 512 words are ever held.
- R4: The first word written into an empty FIFO appears on `dout_o`, with `or_o` at 1, whatever the levels of `ren_ni`, `oe1_ni` and `oe2_ni`.
- R5: A word is consumed on a rising read-clock edge only when `ren_ni`, `oe1_ni` and `oe2_ni` are all 0 and `or_o` is 1. If any of them is 1, `dout_o` and `or_o` hold. `or_o` falls only after a read that leaves nothing behind it.
- R6: While `rst_ni` is 0, `ir_o`, `or_o` and `hf_o` are 0 and `afe_o` is 1. After release, `ir_o` rises within a few write clocks.
- R7: Once the write side has settled, `hf_o` is 1 exactly when 257 or more words are held.
- R8: Once the write side has settled, `afe_o` is 1 exactly when the number of held words is at most the offset, or at least 512 minus the offset. The offset is `ofs_i` if `ofs_load_i` is 1 during reset, and 8 otherwise.
- R9: Data integrity and flag safety hold with the write and read clocks running at unrelated rates and with random enable patterns on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock, free running |
| rclk_i | input | 1 | Read clock, free running |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_i | input | 1 | Write enable, active high |
| wen_ni | input | 1 | Write enable, active low |
| din_i | input | 18 | Write data |
| ir_o | output | 1 | Input ready, write-clock domain |
| ren_ni | input | 1 | Read enable, active low |
| oe1_ni | input | 1 | Read qualifier, active low |
| oe2_ni | input | 1 | Read qualifier, active low |
| dout_o | output | 18 | Output buffer contents |
| or_o | output | 1 | Output ready, read-clock domain |
| hf_o | output | 1 | Half-full flag, write-clock domain |
| afe_o | output | 1 | Near-empty or near-full flag, write-clock domain |
| ofs_load_i | input | 1 | Selects `ofs_i` as the flag offset during reset |
| ofs_i | input | 9 | Flag offset value captured during reset |

## Verification
Directed steps first toggle each write enable alone and each read qualifier alone. This separates a correct AND of the qualifiers from a gate that ignores one input. A single word is then written with reads held off, which shows fall-through as distinct from read-triggered loading. A fill from empty to full stops at the fill levels 8/9, 256/257, 503/504 and 512. There the flag thresholds are compared against off-by-one variants, and blocked writes past full are shown to be dropped rather than to overwrite. A second reset loads a non-default offset. A long random phase with unrelated clock periods and sparse, bursty enables then checks ordering and data across the pointer crossings.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DEF_DEPTH = 512;
  localparam int unsigned DEF_WIDTH = 18;
  localparam int unsigned DEF_OFS   = 8;
endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned DEF_OFS = 8,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic          wen_ni,
  input  logic          ofs_load_i,
  input  logic [AW-1:0] ofs_i,
  input  logic [PW-1:0] cgray_i,
  output logic          wr_en_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          ir_o,
  output logic          hf_o,
  output logic          afe_o
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2 + 1);

  logic [1:0]    rdy_q;
  logic [AW-1:0] ofs_q;
  logic [PW-1:0] cgray_s, cbin_s;
  logic [PW-1:0] wptr_q, wptr_nxt, lvl_nxt, wgray_q;
  logic          ir_q, hf_q, afe_q, wr_fire;

  dcf_gray_sync #(.W(PW)) u_csync (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (cgray_i),
    .q_o   (cgray_s)
  );

  always_comb begin
    for (int i = 0; i < int'(PW); i++) cbin_s[i] = ^(cgray_s >> i);
  end

  // offset captured on write edges while reset is held
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) ofs_q <= ofs_load_i ? ofs_i : AW'(DEF_OFS);
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= '0;
    else         rdy_q <= {rdy_q[0], 1'b1};
  end

  assign wr_fire  = wen_i & ~wen_ni & ir_q;
  assign wptr_nxt = wptr_q + PW'(wr_fire);
  assign lvl_nxt  = wptr_nxt - cbin_s;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      ir_q    <= 1'b0;
      hf_q    <= 1'b0;
      afe_q   <= 1'b1;
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      ir_q    <= rdy_q[1] && (lvl_nxt < DEPTH_P);
      hf_q    <= lvl_nxt >= HALF_P;
      afe_q   <= (lvl_nxt <= {1'b0, ofs_q}) || (lvl_nxt >= DEPTH_P - {1'b0, ofs_q});
    end
  end

  assign wr_en_o = wr_fire;
  assign waddr_o = wptr_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign ir_o    = ir_q;
  assign hf_o    = hf_q;
  assign afe_o   = afe_q;

  assert_no_overflow_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_fire |-> ((wptr_q - cbin_s) < DEPTH_P));

  assert_level_bound_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wptr_q - cbin_s) <= DEPTH_P);

  assert_ptr_hold_R2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !(wen_i && !wen_ni) |=> $stable(wptr_q));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WIDTH = 18,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             ren_ni,
  input  logic             oe1_ni,
  input  logic             oe2_ni,
  input  logic [PW-1:0]    wgray_i,
  input  logic [WIDTH-1:0] rdata_i,
  output logic [AW-1:0]    raddr_o,
  output logic [PW-1:0]    cgray_o,
  output logic [WIDTH-1:0] dout_o,
  output logic             or_o
);
  logic [PW-1:0]    wgray_s, wbin_s;
  logic [PW-1:0]    rptr_q, cptr_q, cptr_nxt, cgray_q;
  logic [WIDTH-1:0] dout_q;
  logic             or_q, mem_has, rd_fire, load;

  dcf_gray_sync #(.W(PW)) u_wsync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray_i),
    .q_o   (wgray_s)
  );

  always_comb begin
    for (int i = 0; i < int'(PW); i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign mem_has  = rptr_q != wbin_s;
  assign rd_fire  = ~ren_ni & ~oe1_ni & ~oe2_ni & or_q;
  assign load     = mem_has & (~or_q | rd_fire);  // fall-through or refill
  assign cptr_nxt = cptr_q + PW'(rd_fire);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      cptr_q  <= '0;
      cgray_q <= '0;
      or_q    <= 1'b0;
      dout_q  <= '0;
    end else begin
      rptr_q  <= rptr_q + PW'(load);
      cptr_q  <= cptr_nxt;
      cgray_q <= cptr_nxt ^ (cptr_nxt >> 1);
      or_q    <= load | (or_q & ~rd_fire);
      if (load) dout_q <= rdata_i;
    end
  end

  assign raddr_o = rptr_q[AW-1:0];
  assign cgray_o = cgray_q;
  assign dout_o  = dout_q;
  assign or_o    = or_q;

  assert_fall_through_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!or_q && mem_has) |=> or_q);

  assert_or_drop_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $fell(or_q) |-> $past(rd_fire));

  assert_held_word_R3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rptr_q - cptr_q) == PW'(or_q));

  assert_dout_hold_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (or_q && (ren_ni || oe1_ni || oe2_ni)) |=> $stable(dout_q));
endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
  parameter int unsigned DEPTH   = dcf_pkg::DEF_DEPTH,
  parameter int unsigned WIDTH   = dcf_pkg::DEF_WIDTH,
  parameter int unsigned DEF_OFS = dcf_pkg::DEF_OFS,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wen_i,
  input  logic             wen_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic             ir_o,
  input  logic             ren_ni,
  input  logic             oe1_ni,
  input  logic             oe2_ni,
  output logic [WIDTH-1:0] dout_o,
  output logic             or_o,
  output logic             hf_o,
  output logic             afe_o,
  input  logic             ofs_load_i,
  input  logic [AW-1:0]    ofs_i
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic             wr_en;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wgray, cgray;

  always_ff @(posedge wclk_i) begin
    if (wr_en) mem_q[waddr] <= din_i;
  end

  dcf_wr_side #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) u_wr (
    .wclk_i    (wclk_i),
    .rst_ni    (rst_ni),
    .wen_i     (wen_i),
    .wen_ni    (wen_ni),
    .ofs_load_i(ofs_load_i),
    .ofs_i     (ofs_i),
    .cgray_i   (cgray),
    .wr_en_o   (wr_en),
    .waddr_o   (waddr),
    .wgray_o   (wgray),
    .ir_o      (ir_o),
    .hf_o      (hf_o),
    .afe_o     (afe_o)
  );

  dcf_rd_side #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd (
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .ren_ni (ren_ni),
    .oe1_ni (oe1_ni),
    .oe2_ni (oe2_ni),
    .wgray_i(wgray),
    .rdata_i(mem_q[raddr]),
    .raddr_o(raddr),
    .cgray_o(cgray),
    .dout_o (dout_o),
    .or_o   (or_o)
  );
endmodule

// File: tb/dcfifo_ft_tb_top.sv
module dcfifo_ft_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH       = 512;

  logic        wclk = 0, rclk = 0, rst_ni = 0;
  logic        wen_i = 0, wen_ni = 1, ren_ni = 1, oe1_ni = 1, oe2_ni = 1;
  logic        ofs_load_i = 0;
  logic [8:0]  ofs_i = '0;
  logic [17:0] din_i = '0, dout_o;
  logic        ir_o, or_o, hf_o, afe_o;

  int n_chk = 0, n_fail = 0;
  logic [17:0] q[$];

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dcfifo_ft dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wen_i(wen_i), .wen_ni(wen_ni), .din_i(din_i), .ir_o(ir_o),
    .ren_ni(ren_ni), .oe1_ni(oe1_ni), .oe2_ni(oe2_ni),
    .dout_o(dout_o), .or_o(or_o), .hf_o(hf_o), .afe_o(afe_o),
    .ofs_load_i(ofs_load_i), .ofs_i(ofs_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_afe(input int lvl, input int ofs);
    return (lvl <= ofs) || (lvl >= DEPTH - ofs);
  endfunction

  function automatic bit exp_hf(input int lvl);
    return lvl >= DEPTH / 2 + 1;
  endfunction

  task automatic wr_cycle(input logic en, input logic enn, input logic [17:0] d);
    @(negedge wclk);
    wen_i = en; wen_ni = enn; din_i = d;
    if (en && !enn && ir_o) begin
      q.push_back(d);
      if (q.size() > DEPTH) chk(0, "R3 held words", q.size(), DEPTH);
    end
  endtask

  task automatic wr_idle();
    @(negedge wclk);
    wen_i = 0; wen_ni = 1;
  endtask

  task automatic rd_cycle(input logic r, input logic o1, input logic o2);
    @(negedge rclk);
    ren_ni = r; oe1_ni = o1; oe2_ni = o2;
    if (!r && !o1 && !o2 && or_o) begin
      chk(dout_o == q[0], "R1 data order", int'(dout_o), int'(q[0]));
      void'(q.pop_front());
    end
  endtask

  task automatic rd_idle();
    @(negedge rclk);
    ren_ni = 1; oe1_ni = 1; oe2_ni = 1;
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) wr_cycle(1, 0, 18'($urandom));
    wr_idle();
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && q.size() > 0; i++) rd_cycle(0, 0, 0);
    rd_idle();
    settle();
    chk(q.size() == 0, "R1 all words drained", q.size(), 0);
    chk(or_o == 0, "R5 or low when empty", or_o, 0);
  endtask

  task automatic do_reset(input logic ld, input logic [8:0] ofs);
    @(negedge wclk);
    rst_ni = 0; ofs_load_i = ld; ofs_i = ofs;
    q.delete();
    repeat (6) @(negedge rclk);
    chk(ir_o == 0, "R6 ir in reset", ir_o, 0);
    chk(or_o == 0, "R6 or in reset", or_o, 0);
    chk(hf_o == 0, "R6 hf in reset", hf_o, 0);
    chk(afe_o == 1, "R6 afe in reset", afe_o, 1);
    @(negedge wclk);
    rst_ni = 1; ofs_load_i = 0;
    repeat (6) @(negedge wclk);
    chk(ir_o == 1, "R6 ir after release", ir_o, 1);
  endtask

  task automatic lvl_flags(input int ofs);
    settle();
    chk(hf_o == exp_hf(q.size()), "R7 half-full", hf_o, exp_hf(q.size()));
    chk(afe_o == exp_afe(q.size(), ofs), "R8 afe level", afe_o, exp_afe(q.size(), ofs));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [17:0] w0;
    int acc;
    void'($urandom(32'd4242));

    do_reset(0, 9'd0);

    // R2: single enable active stores nothing
    wr_cycle(0, 0, 18'h1111);
    wr_cycle(1, 1, 18'h2222);
    wr_idle();
    settle();
    chk(or_o == 0, "R2 disabled write", or_o, 0);

    // R4: fall-through with read qualifiers inactive
    w0 = 18'h2abcd;
    wr_cycle(1, 0, w0);
    wr_idle();
    settle();
    chk(or_o == 1, "R4 or after first write", or_o, 1);
    chk(dout_o == w0, "R4 fall-through data", int'(dout_o), int'(w0));

    // R5: each qualifier alone blocks the read
    rd_cycle(0, 1, 0); rd_cycle(0, 0, 1); rd_cycle(1, 0, 0);
    rd_idle();
    settle();
    chk(or_o == 1 && dout_o == w0, "R5 qualifier blocks read", or_o, 1);
    drain();

    // R7/R8: fill from empty with default offset 8
    write_n(8);   lvl_flags(8);
    write_n(1);   lvl_flags(8);
    write_n(247); lvl_flags(8);
    write_n(1);   lvl_flags(8);
    write_n(246); lvl_flags(8);
    write_n(1);   lvl_flags(8);

    // R3: fill to full, then blocked writes are dropped
    acc = q.size();
    for (int i = 0; i < 100; i++) begin
      @(negedge wclk);
      if (!ir_o) break;
      wen_i = 1; wen_ni = 0; din_i = 18'($urandom);
      q.push_back(din_i);
    end
    wr_idle();
    chk(q.size() == DEPTH, "R3 capacity", q.size(), DEPTH);
    chk(ir_o == 0, "R3 ir low when full", ir_o, 0);
    lvl_flags(8);
    for (int i = 0; i < 5; i++) wr_cycle(1, 0, 18'h3ffff);
    wr_idle();
    drain();

    // R8: loaded offset 20
    do_reset(1, 9'd20);
    write_n(20); lvl_flags(20);
    write_n(1);  lvl_flags(20);
    drain();

    // R9/R1: random traffic with unrelated clocks
    fork
      for (int i = 0; i < 4000; i++)
        wr_cycle(($urandom % 4) != 0, ($urandom % 5) == 0, 18'($urandom));
      for (int i = 0; i < 2800; i++) begin
        if ((i / 400) % 2 == 1) rd_cycle(($urandom % 6) == 0, 0, 0);
        else rd_cycle(($urandom % 3) == 0, ($urandom % 7) == 0, ($urandom % 7) == 0);
      end
    join
    wr_idle();
    rd_idle();
    chk(q.size() <= DEPTH, "R9 no overflow under random", q.size(), DEPTH);
    drain();

    summary();
  end
endmodule